// File: doc/BRIEF.md
# Execution-Based Debug Command Unit

This block is the debug-module half of a debugger that runs on the hart's own pipeline. It serves a small memory-mapped region that halted harts fetch from and store to. An abstract register-access command is not carried out by datapath muxes. The unit builds two instruction words that the hart fetches and executes. The first word is a load or store between a general-purpose register and the data area, or a nop. The second word is either an `ebreak` or a nop that falls through into the debugger-written program buffer. The program buffer and the data area sit next to each other in one contiguous window, so a program can also treat the data words as scratch memory.

Harts tell the unit what they are doing by storing to fixed addresses. A store of a hart's number to the halt-notice word marks that hart halted. When a command is running, the same store also means the hart is back in its park loop and the command is finished. A store to the fault-notice word ends the running command with an error. Each hart polls its own flag word. Bit 0 tells it to run the generated words, and bit 1 tells it to leave debug mode through the `dret` word. The park-loop code and the debugger transport are outside this block.

Top module: `dbgx_cmd_unit`

## Requirements
- R1: After a synchronous reset, busy is 0, the error code is 0, no hart is marked halted, and every hart's flag word at 0x180+4*hart reads 0.
- R2: With transfer=1 and write=1, the word at 0x3D8 reads as a load into GPR regno from immediate 0x400, rs1=x0. Size code 0 gives funct3 010 with opcode 0000011. Size code 1 gives funct3 011 with opcode 0000011. Size code 2 gives funct3 010 with opcode 0001111.
- R3: With transfer=1 and write=0, the word at 0x3D8 reads as a store of GPR regno to 0x400 off x0. The fields are imm[11:5]=0100000, rs1=0, imm[4:0]=0 and opcode 0100011. funct3 is 010, 011 or 100 for size codes 0, 1 and 2.
- R4: With transfer=0, the word at 0x3D8 reads 0x00000013.
- R5: With execute=0, the word at 0x3DC reads 0x00100073. With execute=1, it reads 0x00000013.
- R6: An accepted command sets busy and sets bit 0 of the target hart's flag word. That bit clears only when the target hart fetches 0x3D8. A fetch by any other hart leaves it set.
- R7: A store of value h < NHARTS to 0x100 sets halted[h]. If the command's target hart makes this store after it has fetched 0x3D8, busy clears the next cycle. Before that fetch, the store does not clear busy.
- R8: A store to 0x104 while busy clears busy and sets the error code to 3.
- R9: A command issued while busy is rejected with error code 1, and the generated words are left unchanged. Size code 3 is rejected with error code 2 and does not set busy. A non-zero error code is never overwritten.
- R10: A resume request sets bit 1 of the flag word only for a hart that is marked halted; for any other hart it has no effect. A fetch of 0x108 by a hart returns 0x7B200073. If that hart's resume bit is set, the fetch also clears the bit and the hart's halted mark.
- R11: The program buffer occupies words 0x3E0 to 0x3FC and data0 starts at 0x400. Debugger index k maps to address 0x3E0+4k. Hart stores into this window are readable afterwards. Every hart read returns its data on the cycle after the request.
- R12: A one-cycle pulse on cmderr_clr returns the error code to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_hart | input | HID_W | Hart that is to run the command |
| cmd_regno | input | 5 | GPR number |
| cmd_size | input | 2 | Access size code: 0=32, 1=64, 2=128, 3=invalid |
| cmd_write | input | 1 | 1 = load the GPR from the data area, 0 = store the GPR to it |
| cmd_transfer | input | 1 | Generate the register move |
| cmd_execute | input | 1 | Continue into the program buffer |
| cmderr_clr | input | 1 | Clear the error code |
| resume_req | input | 1 | Resume strobe |
| resume_hart | input | HID_W | Hart to resume |
| dbg_we | input | 1 | Debugger write into the program buffer or data window |
| dbg_idx | input | BIDX_W | Word index within the window |
| dbg_wdata | input | 32 | Debugger write data |
| mem_req | input | 1 | Hart bus request |
| mem_we | input | 1 | Hart bus store |
| mem_hartid | input | HID_W | Number of the requesting hart |
| mem_addr | input | ADDR_W | Hart bus byte address |
| mem_wdata | input | 32 | Hart store data |
| mem_rdata | output | 32 | Hart read data, one cycle after the request |
| busy | output | 1 | Command in flight |
| cmderr | output | 3 | Sticky error code |
| halted | output | NHARTS | Per-hart halted marks |

## Verification
The hardest state to reach is the middle of a command, after the target hart has fetched its first generated word and before it reports back. This is the only window in which a halt-notice store completes the command. It is also the window in which a second command or a fault store must be told apart. The bench reaches it by acting as the hart over the bus. It fetches 0x3D8 under the target hart's number, and then it issues a competing command, a store from a different hart, or a fault store. A halt-notice store made before that fetch checks that an early park-loop store cannot end a command that has not started.

// File: rtl/dbgx_pkg.sv
package dbgx_pkg;
  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;
  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [31:0] INSN_DRET   = 32'h7B20_0073;
  localparam logic [11:0] DATA_OFFS   = 12'h400;
  localparam logic [6:0]  OPC_LOAD    = 7'b0000011;
  localparam logic [6:0]  OPC_LOADQ   = 7'b0001111;
  localparam logic [6:0]  OPC_STORE   = 7'b0100011;

  typedef enum logic [1:0] {
    SZ_W32  = 2'd0,
    SZ_W64  = 2'd1,
    SZ_W128 = 2'd2,
    SZ_BAD  = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ERR_NONE = 3'd0,
    ERR_BUSY = 3'd1,
    ERR_SIZE = 3'd2,
    ERR_EXC  = 3'd3
  } cmd_err_e;
endpackage

// File: rtl/dbgx_insn_gen.sv
module dbgx_insn_gen
  import dbgx_pkg::*;
(
  input  logic [1:0]  size,
  input  logic        write,
  input  logic        transfer,
  input  logic        execute,
  input  logic [4:0]  regno,
  output logic [31:0] word0,
  output logic [31:0] word1
);
  logic [2:0]  ld_f3, st_f3;
  logic [6:0]  ld_op;
  logic [31:0] ld_word, st_word;

  always_comb begin
    ld_f3 = 3'b010;
    st_f3 = 3'b010;
    ld_op = OPC_LOAD;
    case (acc_size_e'(size))
      SZ_W64: begin
        ld_f3 = 3'b011;
        st_f3 = 3'b011;
      end
      SZ_W128: begin
        ld_op = OPC_LOADQ;
        st_f3 = 3'b100;
      end
      default: ;
    endcase
    ld_word = {DATA_OFFS, 5'd0, ld_f3, regno, ld_op};
    st_word = {DATA_OFFS[11:5], regno, 5'd0, st_f3, DATA_OFFS[4:0], OPC_STORE};
    word0   = transfer ? (write ? ld_word : st_word) : INSN_NOP;
    word1   = execute ? INSN_NOP : INSN_EBREAK;
  end
endmodule

// File: rtl/dbgx_buf.sv
module dbgx_buf #(
  parameter int WORDS = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [31:0]      rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
    rdata <= mem[ridx];
  end
endmodule

// File: rtl/dbgx_flags.sv
module dbgx_flags #(
  parameter int NHARTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NHARTS-1:0] set_go,
  input  logic [NHARTS-1:0] clr_go,
  input  logic [NHARTS-1:0] set_res,
  input  logic [NHARTS-1:0] clr_res,
  input  logic [NHARTS-1:0] set_halt,
  output logic [NHARTS-1:0] go,
  output logic [NHARTS-1:0] res,
  output logic [NHARTS-1:0] halt
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    always_ff @(posedge clk) begin
      if (rst) begin
        go[h]   <= 1'b0;
        res[h]  <= 1'b0;
        halt[h] <= 1'b0;
      end else begin
        go[h]   <= set_go[h] | (go[h] & ~clr_go[h]);
        res[h]  <= set_res[h] | (res[h] & ~clr_res[h]);
        halt[h] <= set_halt[h] | (halt[h] & ~clr_res[h]);
      end
    end
  end
endmodule

// File: rtl/dbgx_cmd_unit.sv
module dbgx_cmd_unit
  import dbgx_pkg::*;
#(
  parameter int NHARTS     = 4,
  parameter int HID_W      = $clog2(NHARTS),
  parameter int ADDR_W     = 12,
  parameter int PROG_WORDS = 8,
  parameter int DATA_WORDS = 4,
  parameter int BIDX_W     = $clog2(PROG_WORDS + DATA_WORDS),
  parameter logic [11:0] HALT_ADDR = 12'h100,
  parameter logic [11:0] EXC_ADDR  = 12'h104,
  parameter logic [11:0] DRET_ADDR = 12'h108,
  parameter logic [11:0] FLAG_BASE = 12'h180
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [HID_W-1:0]  cmd_hart,
  input  logic [4:0]        cmd_regno,
  input  logic [1:0]        cmd_size,
  input  logic              cmd_write,
  input  logic              cmd_transfer,
  input  logic              cmd_execute,
  input  logic              cmderr_clr,
  input  logic              resume_req,
  input  logic [HID_W-1:0]  resume_hart,
  input  logic              dbg_we,
  input  logic [BIDX_W-1:0] dbg_idx,
  input  logic [31:0]       dbg_wdata,
  input  logic              mem_req,
  input  logic              mem_we,
  input  logic [HID_W-1:0]  mem_hartid,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_wdata,
  output logic [31:0]       mem_rdata,
  output logic              busy,
  output logic [2:0]        cmderr,
  output logic [NHARTS-1:0] halted
);
  localparam int BUF_WORDS = PROG_WORDS + DATA_WORDS;
  localparam logic [ADDR_W-1:0] BUF_BASE  = ADDR_W'(32'h400 - 4 * PROG_WORDS);
  localparam logic [ADDR_W-1:0] BUF_END   = ADDR_W'(32'h400 + 4 * DATA_WORDS);
  localparam logic [ADDR_W-1:0] GEN0_ADDR = BUF_BASE - ADDR_W'(8);
  localparam logic [ADDR_W-1:0] GEN1_ADDR = BUF_BASE - ADDR_W'(4);
  localparam logic [ADDR_W-1:0] FLAG_END  = ADDR_W'(FLAG_BASE) + ADDR_W'(4 * NHARTS);

  logic [31:0]       gen0_d, gen1_d, gen0_q, gen1_q;
  logic [HID_W-1:0]  cur_hart;
  logic              running;
  logic [NHARTS-1:0] set_go, clr_go, set_res, clr_res, set_halt, go_v, res_v;
  logic              rd, wr, in_buf, in_flag;
  logic [BIDX_W-1:0] hidx, widx;
  logic [HID_W-1:0]  fidx;
  logic              buf_we;
  logic [31:0]       buf_wdata, buf_rdata, misc_d, misc_q;
  logic              sel_buf_q;
  logic              issue_ok, rej_busy, rej_size, fetch0, halt_wr, done_wr, exc_wr, dret_rd;

  dbgx_insn_gen u_gen (
    .size(cmd_size), .write(cmd_write), .transfer(cmd_transfer),
    .execute(cmd_execute), .regno(cmd_regno), .word0(gen0_d), .word1(gen1_d)
  );

  always_comb begin
    rd      = mem_req & ~mem_we;
    wr      = mem_req & mem_we;
    in_buf  = (mem_addr >= BUF_BASE) && (mem_addr < BUF_END);
    in_flag = (mem_addr >= ADDR_W'(FLAG_BASE)) && (mem_addr < FLAG_END);
    hidx    = BIDX_W'((mem_addr - BUF_BASE) >> 2);
    fidx    = HID_W'((mem_addr - ADDR_W'(FLAG_BASE)) >> 2);

    issue_ok = cmd_valid & ~busy & (cmd_size != 2'(SZ_BAD));
    rej_busy = cmd_valid & busy;
    rej_size = cmd_valid & ~busy & (cmd_size == 2'(SZ_BAD));
    fetch0   = rd && (mem_addr == GEN0_ADDR) && (mem_hartid == cur_hart) && go_v[cur_hart];
    halt_wr  = wr && (mem_addr == ADDR_W'(HALT_ADDR)) && (mem_wdata < 32'(NHARTS));
    done_wr  = halt_wr && busy && running && (mem_wdata[HID_W-1:0] == cur_hart);
    exc_wr   = wr && (mem_addr == ADDR_W'(EXC_ADDR)) && busy;
    dret_rd  = rd && (mem_addr == ADDR_W'(DRET_ADDR)) && res_v[mem_hartid];

    set_go   = '0;
    clr_go   = '0;
    set_res  = '0;
    clr_res  = '0;
    set_halt = '0;
    if (issue_ok) set_go[cmd_hart] = 1'b1;
    if (fetch0 || exc_wr) clr_go[cur_hart] = 1'b1;
    if (resume_req && halted[resume_hart]) set_res[resume_hart] = 1'b1;
    if (dret_rd) clr_res[mem_hartid] = 1'b1;
    if (halt_wr) set_halt[mem_wdata[HID_W-1:0]] = 1'b1;

    buf_we    = (wr && in_buf) || dbg_we;
    widx      = (wr && in_buf) ? hidx : dbg_idx;
    buf_wdata = (wr && in_buf) ? mem_wdata : dbg_wdata;

    if (mem_addr == GEN0_ADDR)                 misc_d = gen0_q;
    else if (mem_addr == GEN1_ADDR)            misc_d = gen1_q;
    else if (mem_addr == ADDR_W'(DRET_ADDR))   misc_d = INSN_DRET;
    else if (in_flag)                          misc_d = {30'd0, res_v[fidx], go_v[fidx]};
    else                                       misc_d = 32'd0;
  end

  dbgx_flags #(.NHARTS(NHARTS)) u_flags (
    .clk(clk), .rst(rst), .set_go(set_go), .clr_go(clr_go), .set_res(set_res),
    .clr_res(clr_res), .set_halt(set_halt), .go(go_v), .res(res_v), .halt(halted)
  );

  dbgx_buf #(.WORDS(BUF_WORDS), .IDX_W(BIDX_W)) u_buf (
    .clk(clk), .we(buf_we), .widx(widx), .wdata(buf_wdata),
    .ridx(hidx), .rdata(buf_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      running   <= 1'b0;
      cmderr    <= 3'(ERR_NONE);
      cur_hart  <= '0;
      gen0_q    <= INSN_NOP;
      gen1_q    <= INSN_EBREAK;
      misc_q    <= 32'd0;
      sel_buf_q <= 1'b0;
    end else begin
      misc_q    <= misc_d;
      sel_buf_q <= in_buf;
      if (issue_ok) begin
        gen0_q   <= gen0_d;
        gen1_q   <= gen1_d;
        cur_hart <= cmd_hart;
        busy     <= 1'b1;
        running  <= 1'b0;
      end else if (done_wr || exc_wr) begin
        busy    <= 1'b0;
        running <= 1'b0;
      end else if (fetch0) begin
        running <= 1'b1;
      end
      if (cmderr_clr) cmderr <= 3'(ERR_NONE);
      else if (cmderr == 3'(ERR_NONE)) begin
        if (rej_busy)      cmderr <= 3'(ERR_BUSY);
        else if (rej_size) cmderr <= 3'(ERR_SIZE);
        else if (exc_wr)   cmderr <= 3'(ERR_EXC);
      end
    end
  end

  assign mem_rdata = sel_buf_q ? buf_rdata : misc_q;
endmodule

// File: rtl/dbgx_cmd_unit_chk.sv
module dbgx_cmd_unit_chk #(
  parameter int NHARTS = 4,
  parameter int ADDR_W = 12,
  parameter logic [11:0] HALT_ADDR = 12'h100,
  parameter logic [11:0] EXC_ADDR  = 12'h104
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_size,
  input logic              cmderr_clr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              busy,
  input logic [2:0]        cmderr,
  input logic [NHARTS-1:0] halted
);
  AST_ISSUE_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !busy && cmd_size != 2'd3) |=> busy);  // R6
  AST_REJECT_KEEPS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && busy) |=> (busy && cmderr != 3'd0));  // R9
  AST_FAULT_ENDS_CMD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr == ADDR_W'(EXC_ADDR) && busy && !cmderr_clr)
    |=> (!busy && cmderr != 3'd0));  // R8
  AST_HALT_NOTICE_MARKS: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we && mem_addr == ADDR_W'(HALT_ADDR) && mem_wdata < 32'(NHARTS))
    |=> (halted != '0));  // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (cmderr != 3'd0 && !cmderr_clr) |=> $stable(cmderr));  // R12
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    cmderr_clr |=> (cmderr == 3'd0));  // R12
endmodule

bind dbgx_cmd_unit dbgx_cmd_unit_chk #(
  .NHARTS(NHARTS), .ADDR_W(ADDR_W), .HALT_ADDR(HALT_ADDR), .EXC_ADDR(EXC_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_size(cmd_size),
  .cmderr_clr(cmderr_clr), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .busy(busy), .cmderr(cmderr), .halted(halted)
);

// File: tb/dbgx_cmd_unit_test.sv
module dbgx_cmd_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 0, cmd_write = 0, cmd_transfer = 0, cmd_execute = 0;
  logic [1:0]  cmd_hart = 0, cmd_size = 0, resume_hart = 0, mem_hartid = 0;
  logic [4:0]  cmd_regno = 0;
  logic        cmderr_clr = 0, resume_req = 0, dbg_we = 0, mem_req = 0, mem_we = 0;
  logic [3:0]  dbg_idx = 0;
  logic [31:0] dbg_wdata = 0, mem_wdata = 0, mem_rdata;
  logic [11:0] mem_addr = 0;
  logic        busy;
  logic [2:0]  cmderr;
  logic [3:0]  halted;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  dbgx_cmd_unit uut (.*);

  typedef struct packed {
    logic [1:0]  size;
    logic        wr;
    logic        xfer;
    logic        exec;
    logic [4:0]  regno;
    logic [31:0] w0;
    logic [31:0] w1;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{2'd0, 1'b1, 1'b1, 1'b0, 5'd5,  32'h4000_2283, 32'h0010_0073},
    '{2'd1, 1'b1, 1'b1, 1'b1, 5'd10, 32'h4000_3503, 32'h0000_0013},
    '{2'd2, 1'b1, 1'b1, 1'b0, 5'd1,  32'h4000_208F, 32'h0010_0073},
    '{2'd0, 1'b0, 1'b1, 1'b1, 5'd6,  32'h4060_2023, 32'h0000_0013},
    '{2'd1, 1'b0, 1'b1, 1'b0, 5'd31, 32'h41F0_3023, 32'h0010_0073},
    '{2'd2, 1'b0, 1'b1, 1'b0, 5'd2,  32'h4020_4023, 32'h0010_0073},
    '{2'd0, 1'b0, 1'b0, 1'b1, 5'd7,  32'h0000_0013, 32'h0000_0013},
    '{2'd1, 1'b1, 1'b0, 1'b0, 5'd3,  32'h0000_0013, 32'h0010_0073}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] h, input logic [4:0] r, input logic [1:0] sz,
                       input logic w, input logic t, input logic e);
    @(negedge clk);
    cmd_valid = 1; cmd_hart = h; cmd_regno = r; cmd_size = sz;
    cmd_write = w; cmd_transfer = t; cmd_execute = e;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic hrd(input logic [1:0] h, input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 0; mem_hartid = h; mem_addr = a;
    @(negedge clk);
    d = mem_rdata;
    mem_req = 0;
  endtask

  task automatic hwr(input logic [1:0] h, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    mem_req = 1; mem_we = 1; mem_hartid = h; mem_addr = a; mem_wdata = d;
    @(negedge clk);
    mem_req = 0; mem_we = 0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); cmderr_clr = 1;
    @(negedge clk); cmderr_clr = 0;
  endtask

  task automatic resume(input logic [1:0] h);
    @(negedge clk); resume_req = 1; resume_hart = h;
    @(negedge clk); resume_req = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check("R1 busy", 32'(busy), 0);
    check("R1 cmderr", 32'(cmderr), 0);
    check("R1 halted", 32'(halted), 0);
    hrd(0, 12'h180, rv); check("R1 flag0", rv, 0);
    hrd(3, 12'h18C, rv); check("R1 flag3", rv, 0);

    // R10 resume only for halted harts
    hwr(2, 12'h100, 32'd2);
    check("R7 halt mark", 32'(halted), 32'h4);
    resume(3);
    hrd(3, 12'h18C, rv); check("R10 resume ignored", rv, 0);
    resume(2);
    hrd(2, 12'h188, rv); check("R10 resume flag", rv, 32'h2);
    hrd(2, 12'h108, rv); check("R10 dret word", rv, 32'h7B20_0073);
    hrd(2, 12'h188, rv); check("R10 resume cleared", rv, 0);
    check("R10 halted cleared", 32'(halted), 0);

    // Table walk: R2..R5, R6, R7
    for (int i = 0; i < 8; i++) begin
      logic [1:0] h;
      h = 2'(i % 4);
      issue(h, VECS[i].regno, VECS[i].size, VECS[i].wr, VECS[i].xfer, VECS[i].exec);
      check("R6 busy set", 32'(busy), 1);
      hrd(h, 12'h180 + 12'(4 * i % 16), rv); check("R6 go set", rv, 1);
      hrd(h, 12'h3D8, rv);
      check(VECS[i].xfer ? (VECS[i].wr ? "R2 load word" : "R3 store word") : "R4 nop word",
            rv, VECS[i].w0);
      hrd(h, 12'h3DC, rv); check("R5 second word", rv, VECS[i].w1);
      hwr(h, 12'h100, 32'(h));
      check("R7 done", 32'(busy), 0);
    end

    // R6 go cleared only by target hart, R7 early halt store ignored
    issue(3, 5'd4, 2'd0, 1'b0, 1'b1, 1'b0);
    hwr(3, 12'h100, 32'd3);
    check("R7 early notice keeps busy", 32'(busy), 1);
    hrd(0, 12'h3D8, rv);
    hrd(3, 12'h18C, rv); check("R6 go kept on other fetch", rv, 1);
    hrd(3, 12'h3D8, rv);
    hrd(3, 12'h18C, rv); check("R6 go cleared", rv, 0);
    hwr(1, 12'h100, 32'd1);
    check("R7 other hart keeps busy", 32'(busy), 1);
    hwr(3, 12'h100, 32'd3);
    check("R7 target completes", 32'(busy), 0);

    // R9 busy reject, R12 clear, R8 fault
    issue(1, 5'd9, 2'd0, 1'b1, 1'b1, 1'b0);
    issue(2, 5'd8, 2'd1, 1'b0, 1'b0, 1'b1);
    check("R9 busy reject code", 32'(cmderr), 1);
    check("R9 still busy", 32'(busy), 1);
    hrd(1, 12'h3D8, rv); check("R9 words unchanged", rv, 32'h4000_2483);
    pulse_clr();
    check("R12 cleared", 32'(cmderr), 0);
    hwr(1, 12'h104, 32'd0);
    check("R8 fault ends busy", 32'(busy), 0);
    check("R8 fault code", 32'(cmderr), 3);
    issue(0, 5'd1, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R9 sticky over size", 32'(cmderr), 3);
    pulse_clr();
    issue(0, 5'd1, 2'd3, 1'b1, 1'b1, 1'b0);
    check("R9 size code", 32'(cmderr), 2);
    check("R9 size no busy", 32'(busy), 0);
    pulse_clr();

    // R11 buffer window
    @(negedge clk); dbg_we = 1; dbg_idx = 4'd0; dbg_wdata = 32'hA5A5_0001;
    @(negedge clk); dbg_idx = 4'd8; dbg_wdata = 32'h5A5A_0008;
    @(negedge clk); dbg_we = 0;
    hrd(0, 12'h3E0, rv); check("R11 progbuf word0", rv, 32'hA5A5_0001);
    hrd(0, 12'h400, rv); check("R11 data0", rv, 32'h5A5A_0008);
    hwr(2, 12'h404, 32'h0000_1234);
    hrd(1, 12'h404, rv); check("R11 hart store", rv, 32'h0000_1234);
    hrd(1, 12'h400, rv); check("R11 data0 kept", rv, 32'h5A5A_0008);

    finish_run();
  end
endmodule